// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a 32-bit integer datapath. It takes an operation code, a first operand, a second operand that an upstream shifter has already processed, the shifter's carry-out, a set-flags request and the current condition flags. From these it produces a result word, a write enable for the destination register, and the next values of the negative (N), zero (Z), carry (C) and overflow (V) flags.

There are three arithmetic operations: add, add-with-carry and subtract. There are six logical and move operations: AND, OR, exclusive-OR, bit-clear, move and move-complement. Three further operations only set flags: compare, test and test-equivalence. These three always update the flags and never write a result. Every other operation updates the flags only when set-flags is high. Add-with-carry consumes the incoming C flag, so a flag-setting add followed by an add-with-carry builds a 64-bit sum from two 32-bit halves. The flag vector is packed as {N, Z, C, V}, with N in bit 3 and V in bit 0.

Top module: `dp_alu`

## Requirements
- R1: The arithmetic codes produce these results. Code 4'h3 gives `opnd_a + opnd_b`. Code 4'h4 gives `opnd_a + opnd_b + C`, where C is `flags_in[1]`. Code 4'h2 gives `opnd_a - opnd_b`. All three are modulo 2^32.
- R2: The logical and move codes produce these results. 4'h0 gives `a & b`. 4'h8 gives `a | b`. 4'h1 gives `a ^ b`. 4'hA gives `a & ~b`. 4'h9 gives `b`. 4'hB gives `~b`.
- R3: The flag-only codes are 4'h7 (`a - b`), 4'h5 (`a & b`) and 4'h6 (`a ^ b`). They hold `result_we` at 0, drive the computed value on `result`, and update `flags_out` whatever the state of `set_flags`.
- R4: When the flags are updated, N (`flags_out[3]`) equals bit 31 of the computed value, and Z (`flags_out[2]`) is 1 exactly when the computed value is zero.
- R5: When flags are updated by an add, add-with-carry, subtract or compare, C (`flags_out[1]`) is the carry out of bit 31, and V (`flags_out[0]`) is the two's-complement overflow. For subtract and compare, C=1 means no borrow occurred.
- R6: When flags are updated by a logical, move, test or test-equivalence code, C takes `shift_cout` and V keeps `flags_in[0]`.
- R7: For every valid code other than 4'h5, 4'h6 and 4'h7, `flags_out` equals `flags_in` while `set_flags` is 0.
- R8: Codes 4'hC to 4'hF drive `result` to zero and hold `result_we` at 0. They copy `flags_in` to `flags_out` even when `set_flags` is 1.
- R9: `result_we` is 1 for each of the nine result-writing codes (4'h0-4'h4 and 4'h8-4'hB).
- R10: A flag-setting add of two low words, followed by an add-with-carry of the two high words that uses the C flag from the first step, yields the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_cout | input | 1 | Carry out of the upstream shifter |
| set_flags | input | 1 | Request a flag update for result-writing codes |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| result_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench targets the boundary carries, where a design could get C or V wrong:
- An all-ones plus one add must wrap to zero with C set and V clear. A design that mixes up carry and overflow would report V there.
- The most-positive value plus one must set V.
- Subtracting one from the most-negative value must set both V and C. A design that treats C as a borrow would invert C on every subtract.

The bench also checks that add-with-carry consumes C. Otherwise the 64-bit chain loses its high-word increment.

Two further checks guard against silent flag changes:
- Logical codes must leave V alone and take C from the shifter.
- Unused codes must not write and must not change flags even with set-flags high. Without this check, spurious flag updates would pass unseen.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0,
      OP_XOR = 4'h1,
      OP_SUB = 4'h2,
      OP_ADD = 4'h3,
      OP_ADC = 4'h4,
      OP_TST = 4'h5,
      OP_TEQ = 4'h6,
      OP_CMP = 4'h7,
      OP_ORR = 4'h8,
      OP_MOV = 4'h9,
      OP_BIC = 4'hA,
      OP_MVN = 4'hB
   } alu_op_e;

   typedef enum logic [2:0] {
      LG_AND = 3'd0,
      LG_ORR = 3'd1,
      LG_XOR = 3'd2,
      LG_BIC = 3'd3,
      LG_MOV = 3'd4,
      LG_MVN = 3'd5
   } logic_sel_e;

   typedef struct packed {
      logic       valid;
      logic       use_adder;
      logic       invert_b;
      logic       carry_from_flag;
      logic_sel_e lsel;
      logic       writes;
      logic       forced_flags;
   } alu_ctrl_t;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
   localparam int FLAG_W = 4;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
   import dp_alu_pkg::*;
(
   input  logic [3:0] op_code,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl                 = '0;
      ctrl.lsel            = LG_AND;
      case (op_code)
         OP_ADD: begin
            ctrl.valid = 1'b1; ctrl.use_adder = 1'b1; ctrl.writes = 1'b1;
         end
         OP_ADC: begin
            ctrl.valid = 1'b1; ctrl.use_adder = 1'b1; ctrl.writes = 1'b1;
            ctrl.carry_from_flag = 1'b1;
         end
         OP_SUB: begin
            ctrl.valid = 1'b1; ctrl.use_adder = 1'b1; ctrl.writes = 1'b1;
            ctrl.invert_b = 1'b1;
         end
         OP_CMP: begin
            ctrl.valid = 1'b1; ctrl.use_adder = 1'b1; ctrl.invert_b = 1'b1;
            ctrl.forced_flags = 1'b1;
         end
         OP_AND: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_AND;
         end
         OP_ORR: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_ORR;
         end
         OP_XOR: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_XOR;
         end
         OP_BIC: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_BIC;
         end
         OP_MOV: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_MOV;
         end
         OP_MVN: begin
            ctrl.valid = 1'b1; ctrl.writes = 1'b1; ctrl.lsel = LG_MVN;
         end
         OP_TST: begin
            ctrl.valid = 1'b1; ctrl.forced_flags = 1'b1; ctrl.lsel = LG_AND;
         end
         OP_TEQ: begin
            ctrl.valid = 1'b1; ctrl.forced_flags = 1'b1; ctrl.lsel = LG_XOR;
         end
         default: ctrl.valid = 1'b0;
      endcase
   end

   always_comb begin : chk_decode
      if (!$isunknown(op_code)) begin
         AST_FLAG_ONLY_NO_WRITE: assert (!(ctrl.forced_flags && ctrl.writes))
            else $error("flag-only code also writes"); // R3
      end
   end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              invert_b,
   input  logic              carry_from_flag,
   input  logic              flag_c,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] bb;
   logic              cin;

   assign bb  = invert_b ? ~b : b;
   assign cin = invert_b | (carry_from_flag & flag_c);

   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu_adder: DATA_W must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("dp_alu_adder: ADDER_STYLE must be 0 or 1");
   end

   if (ADDER_STYLE == 1) begin : g_ripple
      logic [DATA_W:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]   = a[i] ^ bb[i] ^ c[i];
         assign c[i+1]   = (a[i] & bb[i]) | (c[i] & (a[i] ^ bb[i]));
      end
      assign cout = c[DATA_W];
      assign ovf  = c[DATA_W] ^ c[MSB];
   end else begin : g_behav
      logic [DATA_W:0] wide;
      assign wide = {1'b0, a} + {1'b0, bb} + {{DATA_W{1'b0}}, cin};
      assign sum  = wide[MSB:0];
      assign cout = wide[DATA_W];
      assign ovf  = (a[MSB] == bb[MSB]) && (wide[MSB] != a[MSB]);
   end

   always_comb begin : chk_adder
      if (!$isunknown({a, b, invert_b, carry_from_flag, flag_c})) begin
         AST_OVF_SIGN_FLIP: assert (!ovf || (sum[MSB] != a[MSB]))
            else $error("overflow without sign change"); // R5
      end
   end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic_sel_e        lsel,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      case (lsel)
         LG_AND:  y = a & b;
         LG_ORR:  y = a | b;
         LG_XOR:  y = a ^ b;
         LG_BIC:  y = a & ~b;
         LG_MOV:  y = b;
         LG_MVN:  y = ~b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              valid,
   input  logic              forced_flags,
   input  logic              set_flags,
   input  logic              use_adder,
   input  logic [DATA_W-1:0] value,
   input  logic              add_c,
   input  logic              add_v,
   input  logic              shift_c,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out
);

   logic update;

   assign update = valid & (forced_flags | set_flags);

   always_comb begin
      flags_out = flags_in;
      if (update) begin
         flags_out[FLAG_N] = value[DATA_W-1];
         flags_out[FLAG_Z] = ~|value;
         flags_out[FLAG_C] = use_adder ? add_c : shift_c;
         flags_out[FLAG_V] = use_adder ? add_v : flags_in[FLAG_V];
      end
   end

   always_comb begin : chk_flags
      if (!$isunknown({valid, forced_flags, set_flags, use_adder, flags_in})) begin
         AST_LOGIC_KEEPS_V: assert (use_adder || (flags_out[FLAG_V] == flags_in[FLAG_V]))
            else $error("logical op changed V"); // R6
      end
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              shift_cout,
   input  logic              set_flags,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic [FLAG_W-1:0] flags_out
);

   alu_ctrl_t         ctrl;
   logic [DATA_W-1:0] add_sum;
   logic              add_c;
   logic              add_v;
   logic [DATA_W-1:0] logic_y;
   logic [DATA_W-1:0] value;

   dp_alu_decode u_decode (
      .op_code (op_code),
      .ctrl    (ctrl)
   );

   dp_alu_adder #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_adder (
      .a               (opnd_a),
      .b               (opnd_b),
      .invert_b        (ctrl.invert_b),
      .carry_from_flag (ctrl.carry_from_flag),
      .flag_c          (flags_in[FLAG_C]),
      .sum             (add_sum),
      .cout            (add_c),
      .ovf             (add_v)
   );

   dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a    (opnd_a),
      .b    (opnd_b),
      .lsel (ctrl.lsel),
      .y    (logic_y)
   );

   assign value     = !ctrl.valid ? '0 : (ctrl.use_adder ? add_sum : logic_y);
   assign result    = value;
   assign result_we = ctrl.valid & ctrl.writes;

   dp_alu_flags #(.DATA_W(DATA_W)) u_flags (
      .valid        (ctrl.valid),
      .forced_flags (ctrl.forced_flags),
      .set_flags    (set_flags),
      .use_adder    (ctrl.use_adder),
      .value        (value),
      .add_c        (add_c),
      .add_v        (add_v),
      .shift_c      (shift_cout),
      .flags_in     (flags_in),
      .flags_out    (flags_out)
   );

   always_comb begin : chk_top
      if (!$isunknown({op_code, opnd_a, opnd_b, shift_cout, set_flags, flags_in})) begin
         AST_CMP_TST_NO_WRITE: assert (!((op_code == OP_CMP || op_code == OP_TST ||
                                          op_code == OP_TEQ) && result_we))
            else $error("flag-only code wrote a result"); // R3
         AST_UNUSED_QUIET: assert (!(op_code >= 4'hC) ||
                                   (!result_we && flags_out == flags_in && result == '0))
            else $error("unused code had an effect"); // R8
         AST_NO_SET_HOLDS: assert (set_flags || op_code == OP_CMP || op_code == OP_TST ||
                                   op_code == OP_TEQ || flags_out == flags_in)
            else $error("flags moved without set_flags"); // R7
         AST_N_FOLLOWS_MSB: assert (flags_out[FLAG_N] == flags_in[FLAG_N] ||
                                    flags_out[FLAG_N] == result[DATA_W-1])
            else $error("N not taken from result"); // R4
         AST_ADD_CARRY: assert (!(op_code == OP_ADD && set_flags) ||
                                (flags_out[FLAG_C] == (result < opnd_a)))
            else $error("add carry mismatch"); // R5
      end
   end

endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;

   typedef struct packed {
      logic [3:0]  req;
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic        sc;
      logic        sf;
      logic [3:0]  fin;
      logic [31:0] res;
      logic        we;
      logic [3:0]  fout;
   } vec_t;

   localparam int NV = 21;
   // fields: req, op, a, b, sc, sf, fin, res, we, fout{N,Z,C,V}
   localparam vec_t VECS [NV] = '{
      {4'd1,  4'h3, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 4'b0000, 32'h00000003, 1'b1, 4'b0000}, // R1 add
      {4'd5,  4'h3, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 4'b0000, 32'h00000000, 1'b1, 4'b0110}, // R5 wrap
      {4'd5,  4'h3, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b1, 4'b0000, 32'h80000000, 1'b1, 4'b1001}, // R5 ovf
      {4'd7,  4'h3, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 4'b1111, 32'h80000000, 1'b1, 4'b1111}, // R7
      {4'd5,  4'h2, 32'h00000005, 32'h00000003, 1'b0, 1'b1, 4'b0000, 32'h00000002, 1'b1, 4'b0010}, // R5 sub
      {4'd5,  4'h2, 32'h00000003, 32'h00000005, 1'b0, 1'b1, 4'b0000, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R5 borrow
      {4'd5,  4'h2, 32'h80000000, 32'h00000001, 1'b0, 1'b1, 4'b0000, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R5 sub ovf
      {4'd1,  4'h4, 32'h00000001, 32'h00000002, 1'b0, 1'b0, 4'b0010, 32'h00000004, 1'b1, 4'b0010}, // R1 adc
      {4'd5,  4'h4, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'b0010, 32'h00000000, 1'b1, 4'b0110}, // R5 adc
      {4'd6,  4'h0, 32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 1'b1, 4'b0001, 32'hF000F000, 1'b1, 4'b1011}, // R6 and
      {4'd2,  4'h8, 32'h0000000F, 32'h000000F0, 1'b0, 1'b1, 4'b0011, 32'h000000FF, 1'b1, 4'b0001}, // R2 orr
      {4'd4,  4'h1, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b1, 1'b1, 4'b0000, 32'h00000000, 1'b1, 4'b0110}, // R4 xor
      {4'd2,  4'hA, 32'h02FA62CA, 32'h0000FFFF, 1'b0, 1'b0, 4'b0000, 32'h02FA0000, 1'b1, 4'b0000}, // R2 bic
      {4'd6,  4'h9, 32'h12345678, 32'hCAFEBABE, 1'b0, 1'b1, 4'b0010, 32'hCAFEBABE, 1'b1, 4'b1000}, // R6 mov
      {4'd9,  4'hB, 32'h00000000, 32'h00000004, 1'b0, 1'b0, 4'b0000, 32'hFFFFFFFB, 1'b1, 4'b0000}, // R9 mvn
      {4'd3,  4'h5, 32'h00000006, 32'h00000001, 1'b0, 1'b0, 4'b0000, 32'h00000000, 1'b0, 4'b0100}, // R3 tst
      {4'd3,  4'h5, 32'h00000007, 32'h00000001, 1'b0, 1'b0, 4'b0100, 32'h00000001, 1'b0, 4'b0000}, // R3 tst
      {4'd3,  4'h6, 32'h00000005, 32'h00000005, 1'b1, 1'b0, 4'b0000, 32'h00000000, 1'b0, 4'b0110}, // R3 teq
      {4'd6,  4'h6, 32'h00000005, 32'h00000004, 1'b0, 1'b0, 4'b0001, 32'h00000001, 1'b0, 4'b0001}, // R6 teq
      {4'd3,  4'h7, 32'h00000005, 32'h00000005, 1'b0, 1'b0, 4'b0000, 32'h00000000, 1'b0, 4'b0110}, // R3 cmp
      {4'd8,  4'hC, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 4'b1010, 32'h00000000, 1'b0, 4'b1010}  // R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = 4'h0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        shift_cout = 1'b0;
   logic        set_flags = 1'b0;
   logic [3:0]  flags_in = 4'h0;
   logic [31:0] result;
   logic        result_we;
   logic [3:0]  flags_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dp_alu uut (
      .op_code    (op_code),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .shift_cout (shift_cout),
      .set_flags  (set_flags),
      .flags_in   (flags_in),
      .result     (result),
      .result_we  (result_we),
      .flags_out  (flags_out)
   );

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic sc, input logic sf, input logic [3:0] fin);
      @(negedge clk);
      op_code = op; opnd_a = a; opnd_b = b;
      shift_cout = sc; set_flags = sf; flags_in = fin;
      #5;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] lo, hi;
      logic [3:0]  cflag;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // idle state: all-zero inputs select AND with no flag request (R2, R7)
      apply(4'h0, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);
      check32("R2", "idle result", result, 32'h0);
      check32("R9", "idle we", {31'b0, result_we}, 32'h1);
      check32("R7", "idle flags", {28'b0, flags_out}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sc, VECS[i].sf, VECS[i].fin);
         check32(tag, "result", result, VECS[i].res);
         check32(tag, "we", {31'b0, result_we}, {31'b0, VECS[i].we});
         check32(tag, "flags", {28'b0, flags_out}, {28'b0, VECS[i].fout});
      end

      // R8: every unused code, set_flags high, is quiet
      for (int op = 12; op < 16; op++) begin
         apply(op[3:0], 32'hDEADBEEF, 32'h12345678, 1'b1, 1'b1, 4'b0110);
         check32("R8", "unused we", {31'b0, result_we}, 32'h0);
         check32("R8", "unused flags", {28'b0, flags_out}, 32'h6);
         check32("R8", "unused result", result, 32'h0);
      end

      // R10: 64-bit add 0x1_FFFFFFFF + 0x2_00000001 = 0x4_00000000
      apply(4'h3, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 4'b0000);
      lo = result;
      cflag = flags_out;
      apply(4'h4, 32'h00000001, 32'h00000002, 1'b0, 1'b1, cflag);
      hi = result;
      check32("R10", "low word", lo, 32'h00000000);
      check32("R10", "high word", hi, 32'h00000004);

      // R1: subtract of equal values gives zero; R4 Z set
      apply(4'h2, 32'h89ABCDEF, 32'h89ABCDEF, 1'b0, 1'b1, 4'b1001);
      check32("R1", "sub equal", result, 32'h0);
      check32("R4", "sub equal flags", {28'b0, flags_out}, 32'h6);

      // R3: compare of 3 and 5 writes nothing, sets N
      apply(4'h7, 32'h00000003, 32'h00000005, 1'b0, 1'b0, 4'b0000);
      check32("R3", "cmp we", {31'b0, result_we}, 32'h0);
      check32("R3", "cmp flags", {28'b0, flags_out}, 32'h8);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule